// File: doc/BRIEF.md
# Carry-Fill Right Shifter with Condition Flags

This block is a 16-bit execution unit that moves a data word right by a variable number of places, from 0 to 16. The upper positions left empty by the move are not cleared to zero. Each one takes a copy of the carry flag as it stood before the operation. Alongside the shifted word, the unit produces fresh negative (N), zero (Z), overflow (V) and carry (C) flags.

The shift count comes from one of two sources, chosen by `mode_reg`. The first source is a 4-bit immediate field, where the value 0 stands for a full 16-place shift. The second is a 16-bit count register value, where any value above 15 saturates to 16.

A caller presents the operands and pulses `start` for one cycle. The result and flags are registered and appear one clock later, together with a one-cycle `done` pulse. They then hold until the next `start`. The output side has no back-pressure: the consumer must accept the result in the cycle `done` is high, and `start` may be pulsed on every cycle.

Top module: `cfill_shr_unit`

## Requirements
- R1: The result equals the operand shifted right by n places (0 <= n <= 16). Each of the top n result bits equals `carry_in`.
- R2: With `mode_reg` = 0 (immediate source), n equals `imm_cnt`, except that `imm_cnt` = 0 gives n = 16.
- R3: With `mode_reg` = 1 (register source), n equals `reg_cnt` when `reg_cnt` <= 15, and n = 16 for any larger value. `reg_cnt` = 0 gives n = 0, so the result equals the operand.
- R4: For n > 0, `flag_c` becomes bit n-1 of the operand before the shift. For n = 16 that is operand bit 15.
- R5: For n = 0, `flag_c` equals `carry_in`, so the carry is unchanged.
- R6: `flag_n` equals bit 15 of the result.
- R7: `flag_z` is 1 exactly when the 16-bit result is zero.
- R8: `flag_v` equals operand bit 15 XOR result bit 15. It is updated for every n, including n = 0.
- R9: Result and flags are registered on the clock edge where `start` is sampled high. `done` is high for exactly the following cycle. Without `start`, the outputs hold their values.
- R10: A synchronous reset (`rst` high at a clock edge) clears the result, all four flags and `done` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request strobe; operands are sampled with it |
| mode_reg | input | 1 | Count source: 0 = immediate field, 1 = count register |
| imm_cnt | input | 4 | Immediate shift count; 0 means 16 |
| reg_cnt | input | 16 | Count register value; above 15 means 16 |
| operand | input | 16 | Data word to shift |
| carry_in | input | 1 | Current carry flag, used as the fill bit |
| result | output | 16 | Registered shifted word |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |
| done | output | 1 | One-cycle pulse marking fresh result and flags |

## Verification
Every output of this block is due exactly one rising edge after the edge that samples `start`. `done` is due on that same edge and falls one edge later. The bench drives operands on the falling edge and updates its reference model at that moment. It compares all outputs against the model at the next falling edge, which comes half a period after the register stage has taken its value. Idle cycles between requests check that result and flags hold, while back-to-back strobes check that a new value replaces the old one on every edge.

// File: rtl/cfs_pkg.sv
package cfs_pkg;

  // Count source selector driven by mode_reg.
  typedef enum logic {
    CNT_IMM = 1'b0,
    CNT_REG = 1'b1
  } cnt_src_e;

  // Condition flag bundle.
  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;

endpackage

// File: rtl/cfs_count_sel.sv
module cfs_count_sel
  import cfs_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IMM_W  = 4,
  parameter int CNT_W  = 16,
  parameter int SH_W   = $clog2(DATA_W + 1)
) (
  input  cnt_src_e          src,
  input  logic [IMM_W-1:0]  imm_cnt,
  input  logic [CNT_W-1:0]  reg_cnt,
  output logic [SH_W-1:0]   shamt
);

  localparam logic [SH_W-1:0]  FULL     = SH_W'(DATA_W);
  localparam logic [CNT_W-1:0] REG_SAT  = CNT_W'(DATA_W);

  logic [SH_W-1:0] imm_n;
  logic [SH_W-1:0] reg_n;

  // An immediate of zero encodes the full-width shift.
  always_comb begin
    if (imm_cnt == '0) imm_n = FULL;
    else               imm_n = SH_W'(imm_cnt);
  end

  // A register count at or beyond the width saturates to the full width.
  always_comb begin
    if (reg_cnt >= REG_SAT) reg_n = FULL;
    else                    reg_n = reg_cnt[SH_W-1:0];
  end

  assign shamt = (src == CNT_REG) ? reg_n : imm_n;

endmodule

// File: rtl/cfs_fill_shifter.sv
module cfs_fill_shifter #(
  parameter int DATA_W = 16,
  parameter int SH_W   = $clog2(DATA_W + 1)
) (
  input  logic [DATA_W-1:0] din,
  input  logic              fill,
  input  logic [SH_W-1:0]   shamt,
  output logic [DATA_W-1:0] dout,
  output logic              tail
);

  // One guard bit below the word catches the last bit shifted out.
  localparam int EXT_W = DATA_W + 1;

  logic [EXT_W-1:0] stage [SH_W+1];

  assign stage[0] = {din, 1'b0};

  for (genvar s = 0; s < SH_W; s++) begin : g_stage
    localparam int STEP = 1 << s;
    if (STEP < EXT_W) begin : g_part
      always_comb begin
        if (shamt[s]) stage[s+1] = {{STEP{fill}}, stage[s][EXT_W-1:STEP]};
        else          stage[s+1] = stage[s];
      end
    end else begin : g_all
      always_comb begin
        if (shamt[s]) stage[s+1] = {EXT_W{fill}};
        else          stage[s+1] = stage[s];
      end
    end
  end

  assign dout = stage[SH_W][EXT_W-1:1];
  assign tail = stage[SH_W][0];

endmodule

// File: rtl/cfs_flag_unit.sv
module cfs_flag_unit
  import cfs_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SH_W   = $clog2(DATA_W + 1)
) (
  input  logic [DATA_W-1:0] op_word,
  input  logic [DATA_W-1:0] res_word,
  input  logic              tail,
  input  logic [SH_W-1:0]   shamt,
  input  logic              cin,
  output flags_t            flags
);

  always_comb begin
    flags.n = res_word[DATA_W-1];
    flags.z = (res_word == '0);
    flags.v = op_word[DATA_W-1] ^ res_word[DATA_W-1];
    flags.c = (shamt == '0) ? cin : tail;
  end

endmodule

// File: rtl/cfill_shr_unit.sv
module cfill_shr_unit
  import cfs_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IMM_W  = 4,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              mode_reg,
  input  logic [IMM_W-1:0]  imm_cnt,
  input  logic [CNT_W-1:0]  reg_cnt,
  input  logic [DATA_W-1:0] operand,
  input  logic              carry_in,
  output logic [DATA_W-1:0] result,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_v,
  output logic              flag_c,
  output logic              done
);

  localparam int SH_W = $clog2(DATA_W + 1);

  cnt_src_e          src;
  logic [SH_W-1:0]   shamt;
  logic [DATA_W-1:0] shifted;
  logic              tail;
  flags_t            nxt_flags;
  flags_t            flags_q;
  logic [DATA_W-1:0] result_q;
  logic              done_q;

  assign src = cnt_src_e'(mode_reg);

  cfs_count_sel #(
    .DATA_W(DATA_W), .IMM_W(IMM_W), .CNT_W(CNT_W), .SH_W(SH_W)
  ) u_count (
    .src     (src),
    .imm_cnt (imm_cnt),
    .reg_cnt (reg_cnt),
    .shamt   (shamt)
  );

  cfs_fill_shifter #(
    .DATA_W(DATA_W), .SH_W(SH_W)
  ) u_shift (
    .din   (operand),
    .fill  (carry_in),
    .shamt (shamt),
    .dout  (shifted),
    .tail  (tail)
  );

  cfs_flag_unit #(
    .DATA_W(DATA_W), .SH_W(SH_W)
  ) u_flags (
    .op_word  (operand),
    .res_word (shifted),
    .tail     (tail),
    .shamt    (shamt),
    .cin      (carry_in),
    .flags    (nxt_flags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_q <= '0;
      flags_q  <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= start;
      if (start) begin
        result_q <= shifted;
        flags_q  <= nxt_flags;
      end
    end
  end

  assign result = result_q;
  assign flag_n = flags_q.n;
  assign flag_z = flags_q.z;
  assign flag_v = flags_q.v;
  assign flag_c = flags_q.c;
  assign done   = done_q;

endmodule

// File: rtl/cfill_shr_chk.sv
module cfill_shr_chk #(
  parameter int DATA_W = 16,
  parameter int IMM_W  = 4,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              mode_reg,
  input logic [IMM_W-1:0]  imm_cnt,
  input logic [CNT_W-1:0]  reg_cnt,
  input logic [DATA_W-1:0] operand,
  input logic              carry_in,
  input logic [DATA_W-1:0] result,
  input logic              flag_n,
  input logic              flag_z,
  input logic              flag_v,
  input logic              flag_c,
  input logic              done
);

  // R9: done follows start by one edge and only then.
  a_r9_done_after_start: assert property (@(posedge clk) disable iff (rst)
    start |=> done);
  a_r9_no_spurious_done: assert property (@(posedge clk) disable iff (rst)
    !start |=> !done);
  a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !start |=> ($stable(result) && $stable(flag_c) && $stable(flag_v)));

  // R6 and R7: registered flags agree with the registered result.
  a_r6_sign_flag: assert property (@(posedge clk) disable iff (rst)
    done |-> (flag_n == result[DATA_W-1]));
  a_r7_zero_flag: assert property (@(posedge clk) disable iff (rst)
    done |-> (flag_z == (result == '0)));

  // R8: overflow compares old sign to new sign.
  a_r8_sign_change: assert property (@(posedge clk) disable iff (rst)
    start |=> (flag_v == ($past(operand[DATA_W-1]) ^ result[DATA_W-1])));

  // R2: immediate zero fills the whole word with the old carry.
  a_r2_imm_zero_full: assert property (@(posedge clk) disable iff (rst)
    (start && !mode_reg && imm_cnt == '0) |=>
      (result == {DATA_W{$past(carry_in)}}) && (flag_c == $past(operand[DATA_W-1])));

  // R3 and R5: register count zero passes the word and keeps the carry.
  a_r5_zero_count_keeps_carry: assert property (@(posedge clk) disable iff (rst)
    (start && mode_reg && reg_cnt == '0) |=>
      (result == $past(operand)) && (flag_c == $past(carry_in)));

endmodule

bind cfill_shr_unit cfill_shr_chk #(
  .DATA_W(DATA_W), .IMM_W(IMM_W), .CNT_W(CNT_W)
) chk_i (.*);

// File: tb/cfill_shr_unit_tb_top.sv
module cfill_shr_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic        mode_reg;
  logic [3:0]  imm_cnt;
  logic [15:0] reg_cnt;
  logic [15:0] operand;
  logic        carry_in;
  logic [15:0] result;
  logic        flag_n, flag_z, flag_v, flag_c, done;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // Reference state
  logic [15:0] e_res;
  logic        e_n, e_z, e_v, e_c, e_done;
  string       e_tag;
  logic [31:0] lfsr = 32'h1ACE_5EED;

  always #10 clk = ~clk;

  cfill_shr_unit dut_i (
    .clk(clk), .rst(rst), .start(start), .mode_reg(mode_reg),
    .imm_cnt(imm_cnt), .reg_cnt(reg_cnt), .operand(operand),
    .carry_in(carry_in), .result(result), .flag_n(flag_n),
    .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c), .done(done)
  );

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(e_tag, "result", result, e_res);
    chk("R6", "flag_n", 16'(flag_n), 16'(e_n));
    chk("R7", "flag_z", 16'(flag_z), 16'(e_z));
    chk("R8", "flag_v", 16'(flag_v), 16'(e_v));
    chk(e_tag == "R3" || e_tag == "R5" ? e_tag : "R4", "flag_c",
        16'(flag_c), 16'(e_c));
    chk("R9", "done", 16'(done), 16'(e_done));
  endtask

  // Behavioural model: decide n, then pick each result bit by index.
  task automatic model(input logic md, input logic [3:0] im, input logic [15:0] rc,
                       input logic [15:0] op, input logic ci);
    int n;
    if (!md) n = (im == 0) ? 16 : int'(im);
    else     n = (rc > 15) ? 16 : int'(rc);
    for (int i = 0; i < 16; i++)
      e_res[i] = (i + n < 16) ? op[i + n] : ci;
    e_c = (n == 0) ? ci : op[n - 1];
    e_n = e_res[15];
    e_z = (e_res == 16'h0);
    e_v = op[15] ^ e_res[15];
    if (n == 0)       e_tag = md ? "R3" : "R5";
    else if (n == 16) e_tag = md ? "R3" : "R2";
    else              e_tag = "R1";
  endtask

  // One cycle: check outputs of the previous edge, then drive new inputs.
  task automatic step(input logic st, input logic md, input logic [3:0] im,
                      input logic [15:0] rc, input logic [15:0] op, input logic ci);
    @(negedge clk);
    compare_all();
    start = st; mode_reg = md; imm_cnt = im; reg_cnt = rc;
    operand = op; carry_in = ci;
    e_done = st;
    if (st) model(md, im, rc, op, ci);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; start = 1'b1; operand = 16'hFFFF; carry_in = 1'b1;
    mode_reg = 1'b0; imm_cnt = 4'd3; reg_cnt = 16'd0;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    // R10: outputs cleared by reset
    chk("R10", "reset result", result, 16'h0);
    chk("R10", "reset flags", 16'({flag_n, flag_z, flag_v, flag_c}), 16'h0);
    chk("R10", "reset done", 16'(done), 16'h0);
    rst = 1'b0;
    e_res = '0; {e_n, e_z, e_v, e_c} = '0; e_done = 1'b0; e_tag = "R10";
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; start = 1'b0; mode_reg = 1'b0; imm_cnt = '0; reg_cnt = '0;
    operand = '0; carry_in = 1'b0;
    repeat (2) @(posedge clk);
    do_reset();

    // R1: immediate counts 1..15 with both carry values
    for (int k = 1; k < 16; k++) step(1, 0, 4'(k), 16'h0, 16'hB5A3, k[0]);
    // R2: immediate zero means 16
    step(1, 0, 4'd0, 16'h0, 16'h8001, 1'b1);
    step(1, 0, 4'd0, 16'h0, 16'h7FFF, 1'b0);
    // R9: idle cycles hold the last values
    step(0, 0, 4'd5, 16'h0, 16'h1234, 1'b1);
    step(0, 1, 4'd5, 16'h3, 16'hFFFF, 1'b0);
    // R3: register counts, zero, in-range, boundary and saturation
    step(1, 1, 4'd9, 16'd0, 16'hC3C3, 1'b1);
    step(1, 1, 4'd0, 16'd0, 16'h0000, 1'b0);
    step(1, 1, 4'd0, 16'd5, 16'hF0F0, 1'b1);
    step(1, 1, 4'd0, 16'd15, 16'h8000, 1'b0);
    step(1, 1, 4'd0, 16'd16, 16'h8000, 1'b0);
    step(1, 1, 4'd0, 16'd17, 16'h0001, 1'b1);
    step(1, 1, 4'd0, 16'hFFFF, 16'h4000, 1'b0);
    // R4: carry out of bit n-1; R7: zero result; R8: sign change
    step(1, 0, 4'd1, 16'h0, 16'h0001, 1'b0);
    step(1, 0, 4'd4, 16'h0, 16'h0008, 1'b0);
    step(1, 0, 4'd1, 16'h0, 16'h8000, 1'b0);
    step(1, 0, 4'd2, 16'h0, 16'h0000, 1'b1);
    step(0, 0, 4'd0, 16'h0, 16'h0000, 1'b0);

    // Pseudo-random requests with random idle gaps
    for (int i = 0; i < 2000; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      lfsr = lfsr * 32'd1103515245 + 32'd12345;
      step(lfsr[3:0] != 4'd0, lfsr[4], lfsr[11:8],
           lfsr[5] ? {11'h0, lfsr[20:16]} : lfsr[31:16], lfsr[27:12], lfsr[6]);
    end

    // R10: reset in the middle of traffic
    do_reset();
    step(1, 1, 4'd0, 16'd3, 16'hA5A5, 1'b1);
    step(0, 0, 4'd0, 16'd0, 16'h0, 1'b0);
    step(0, 0, 4'd0, 16'd0, 16'h0, 1'b0);

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule